// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode

This block is the fetch stage for a byte-coded instruction set in which instructions are 1 to 6 bytes long. Each cycle it takes a window of instruction bytes that memory returned from the current program counter and splits the first byte into an instruction code and a function code. It then finds the optional register byte and the optional little-endian constant, works out the sequential next address, and grades the instruction as normal, halt, bad address or invalid.

A small registered program counter lets the block walk a byte array without help. While the machine is running, the counter moves to the next sequential address on every cycle. The first instruction that is not normal freezes both the counter and the status until reset. Execution, the register file and data memory sit outside this block.

Top module: `vlen_fetch_decode`

## Requirements
- R1: The low nibble of the first window byte (bits 3:0) is the function code, and its high nibble (bits 7:4) is the instruction code. Byte k of the window occupies bits 8k+7:8k.
- R2: The length depends only on the instruction code. It is 1 for codes 0, 1 and 9, 2 for codes 2, 6, A and B, 5 for codes 7 and 8, 6 for codes 3, 4 and 5, and 1 for any code above B. The next address is PC plus length, modulo 2^32.
- R3: Codes 2 to 6, A and B carry a register byte at window byte 1, with the first register ID in its high nibble and the second in its low nibble. For every other code both IDs read 0xF, meaning no register.
- R4: Codes 3, 4 and 5 take a 32-bit little-endian constant from window bytes 2 to 5. Codes 7 and 8 take it from bytes 1 to 4. All other codes give a constant of zero.
- R5: An instruction is invalid (decoded status 4) if its code is above B, if it has a nonzero function code on a code other than 2, 6 or 7, if it has a function code above 6 on code 2 or 7, or if it has a function code above 3 on code 6.
- R6: The instruction-memory error input forces decoded status 3 and overrides every other status.
- R7: A first byte of 0x00 decodes as halt (status 2), so fetching into zeroed memory stops the machine.
- R8: Reset sets the PC to the RESET_PC parameter and the registered status to 1. While both the registered status and the decoded status are 1, the PC loads the next address at each clock.
- R9: The first decoded status that is not 1 is loaded into the registered status, and the PC stays put. From then on the PC and the status do not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_i | input | 48 | Instruction bytes read from pc_o; byte k at bits 8k+7:8k |
| imem_err_i | input | 1 | Instruction memory reports a bad address |
| pc_o | output | 32 | Registered program counter |
| icode_o | output | 4 | Instruction code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register ID (0xF = none) |
| rb_o | output | 4 | Second register ID (0xF = none) |
| valc_o | output | 32 | Decoded constant |
| valp_o | output | 32 | Next sequential address |
| dec_stat_o | output | 3 | Status of the instruction now being decoded |
| stat_o | output | 3 | Registered machine status |

## Verification
The hardest situations to reach are the ones that depend on the registered PC. Sequential-address wraparound only happens when the counter sits near the top of the address space, so the bench builds a second instance whose reset address is 0xFFFFFFFC and feeds it a 6-byte instruction. The freeze after a halt needs a real fetch walk, so the bench serves the window from a byte array indexed by pc_o and runs a short program that ends in zeroed memory. The bench resets before each table vector, which means every non-normal vector reaches the stop logic from a running state.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

   typedef enum logic [2:0] {
      ST_AOK = 3'd1,
      ST_HLT = 3'd2,
      ST_ADR = 3'd3,
      ST_INS = 3'd4
   } vlf_stat_e;

   localparam logic [3:0] IC_HALT  = 4'h0;
   localparam logic [3:0] IC_NOP   = 4'h1;
   localparam logic [3:0] IC_RRMOV = 4'h2;
   localparam logic [3:0] IC_IRMOV = 4'h3;
   localparam logic [3:0] IC_RMMOV = 4'h4;
   localparam logic [3:0] IC_MRMOV = 4'h5;
   localparam logic [3:0] IC_ALU   = 4'h6;
   localparam logic [3:0] IC_JMP   = 4'h7;
   localparam logic [3:0] IC_CALL  = 4'h8;
   localparam logic [3:0] IC_RET   = 4'h9;
   localparam logic [3:0] IC_PUSH  = 4'hA;
   localparam logic [3:0] IC_POP   = 4'hB;

   localparam logic [3:0] FN_MAX_COND = 4'd6;
   localparam logic [3:0] FN_MAX_ALU  = 4'd3;

endpackage

// File: rtl/vlf_classify.sv
module vlf_classify
   import vlf_pkg::*;
#(
   parameter int WORD_BYTES = 4,
   parameter int LEN_W      = 3
) (
   input  logic [3:0]       icode_i,
   input  logic [3:0]       ifun_i,
   output logic             need_reg_o,
   output logic             need_const_o,
   output logic             legal_o,
   output logic [LEN_W-1:0] len_o
);

   always_comb begin
      need_reg_o   = 1'b0;
      need_const_o = 1'b0;
      legal_o      = 1'b0;
      case (icode_i)
         IC_HALT, IC_NOP, IC_RET: legal_o = (ifun_i == 4'd0);
         IC_RRMOV: begin
            need_reg_o = 1'b1;
            legal_o    = (ifun_i <= FN_MAX_COND);
         end
         IC_ALU: begin
            need_reg_o = 1'b1;
            legal_o    = (ifun_i <= FN_MAX_ALU);
         end
         IC_PUSH, IC_POP: begin
            need_reg_o = 1'b1;
            legal_o    = (ifun_i == 4'd0);
         end
         IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
            need_reg_o   = 1'b1;
            need_const_o = 1'b1;
            legal_o      = (ifun_i == 4'd0);
         end
         IC_JMP: begin
            need_const_o = 1'b1;
            legal_o      = (ifun_i <= FN_MAX_COND);
         end
         IC_CALL: begin
            need_const_o = 1'b1;
            legal_o      = (ifun_i == 4'd0);
         end
         default: legal_o = 1'b0;
      endcase
   end

   assign len_o = LEN_W'(1) + LEN_W'(need_reg_o)
                + (need_const_o ? LEN_W'(WORD_BYTES) : LEN_W'(0));

endmodule

// File: rtl/vlf_fields.sv
module vlf_fields #(
   parameter int WIN_BYTES  = 6,
   parameter int WORD_BYTES = 4,
   parameter int REG_W      = 4
) (
   input  logic [8*WIN_BYTES-1:0]  win_i,
   input  logic                    need_reg_i,
   input  logic                    need_const_i,
   output logic [REG_W-1:0]        ra_o,
   output logic [REG_W-1:0]        rb_o,
   output logic [8*WORD_BYTES-1:0] valc_o
);

   localparam logic [REG_W-1:0] REG_NONE = '1;

   assign ra_o = need_reg_i ? win_i[8+REG_W +: REG_W] : REG_NONE;
   assign rb_o = need_reg_i ? win_i[8       +: REG_W] : REG_NONE;

   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_const_byte
      always_comb begin
         if (!need_const_i)
            valc_o[8*k +: 8] = 8'h00;
         else if (need_reg_i)
            valc_o[8*k +: 8] = win_i[8*(2+k) +: 8];
         else
            valc_o[8*k +: 8] = win_i[8*(1+k) +: 8];
      end
   end

endmodule

// File: rtl/vlf_pc_ctrl.sv
module vlf_pc_ctrl
   import vlf_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] valp_i,
   input  vlf_stat_e         dec_stat_i,
   output logic [ADDR_W-1:0] pc_q,
   output vlf_stat_e         stat_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= ADDR_W'(RESET_PC);
         stat_q <= ST_AOK;
      end else if (stat_q == ST_AOK) begin
         stat_q <= dec_stat_i;
         if (dec_stat_i == ST_AOK)
            pc_q <= valp_i;
      end
   end

   AST_FROZEN_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q != ST_AOK) |=> ($stable(pc_q) && $stable(stat_q))); // R9

   AST_RUNNING_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q == ST_AOK && dec_stat_i == ST_AOK) |=> (stat_q == ST_AOK && pc_q != $past(pc_q))); // R8

   AST_STOP_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q == ST_AOK && dec_stat_i != ST_AOK) |=> (stat_q == $past(dec_stat_i) && $stable(pc_q))); // R9

endmodule

// File: rtl/vlen_fetch_decode.sv
module vlen_fetch_decode
   import vlf_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          WIN_BYTES  = 6,
   parameter int          WORD_BYTES = 4,
   parameter int          REG_W      = 4,
   parameter logic [31:0] RESET_PC   = 32'h0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [8*WIN_BYTES-1:0]  win_i,
   input  logic                    imem_err_i,
   output logic [ADDR_W-1:0]       pc_o,
   output logic [3:0]              icode_o,
   output logic [3:0]              ifun_o,
   output logic [REG_W-1:0]        ra_o,
   output logic [REG_W-1:0]        rb_o,
   output logic [8*WORD_BYTES-1:0] valc_o,
   output logic [ADDR_W-1:0]       valp_o,
   output logic [2:0]              dec_stat_o,
   output logic [2:0]              stat_o
);

   localparam int LEN_W = $clog2(WIN_BYTES + 1);

   if (WIN_BYTES < 2 + WORD_BYTES) begin : g_bad_window
      $error("window narrower than the longest instruction");
   end
   if (2 * REG_W != 8) begin : g_bad_regw
      $error("two register IDs must fill one byte");
   end

   logic             need_reg, need_const, legal;
   logic [LEN_W-1:0] len;
   vlf_stat_e        dec_stat, stat_q;

   assign icode_o = win_i[7:4];
   assign ifun_o  = win_i[3:0];

   vlf_classify #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_classify (
      .icode_i      (icode_o),
      .ifun_i       (ifun_o),
      .need_reg_o   (need_reg),
      .need_const_o (need_const),
      .legal_o      (legal),
      .len_o        (len)
   );

   vlf_fields #(.WIN_BYTES(WIN_BYTES), .WORD_BYTES(WORD_BYTES), .REG_W(REG_W)) u_fields (
      .win_i        (win_i),
      .need_reg_i   (need_reg),
      .need_const_i (need_const),
      .ra_o         (ra_o),
      .rb_o         (rb_o),
      .valc_o       (valc_o)
   );

   assign valp_o = pc_o + ADDR_W'(len);

   always_comb begin
      if (imem_err_i)             dec_stat = ST_ADR;
      else if (!legal)            dec_stat = ST_INS;
      else if (icode_o == IC_HALT) dec_stat = ST_HLT;
      else                        dec_stat = ST_AOK;
   end

   vlf_pc_ctrl #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .valp_i     (valp_o),
      .dec_stat_i (dec_stat),
      .pc_q       (pc_o),
      .stat_q     (stat_q)
   );

   assign dec_stat_o = dec_stat;
   assign stat_o     = stat_q;

   AST_LEN_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((valp_o - pc_o) == ADDR_W'(1) || (valp_o - pc_o) == ADDR_W'(2) ||
       (valp_o - pc_o) == ADDR_W'(1 + WORD_BYTES) ||
       (valp_o - pc_o) == ADDR_W'(2 + WORD_BYTES))); // R2

   AST_NO_REG_ID_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      !need_reg |-> (&ra_o && &rb_o)); // R3

   AST_NO_CONST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !need_const |-> (valc_o == '0)); // R4

   AST_MEM_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (imem_err_i && stat_o == 3'd1) |=> (stat_o == 3'd3 && $stable(pc_o))); // R6

endmodule

// File: tb/test_vlen_fetch_decode.sv
module test_vlen_fetch_decode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] vec_win = '0;
   logic        vec_err = 1'b0;
   logic        use_mem = 1'b0;
   logic [47:0] mem_win, win;

   logic [31:0] pc, valc, valp;
   logic [3:0]  icode, ifun, ra, rb;
   logic [2:0]  dstat, stat;

   logic [31:0] w_pc, w_valc, w_valp;
   logic [3:0]  w_icode, w_ifun, w_ra, w_rb;
   logic [2:0]  w_dstat, w_stat;

   logic [7:0] mem [0:31];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   always_comb begin
      for (int k = 0; k < 6; k++)
         mem_win[8*k +: 8] = (pc + 32'(k) < 32'd32) ? mem[pc[4:0] + 5'(k)] : 8'h00;
   end
   assign win = use_mem ? mem_win : vec_win;

   vlen_fetch_decode i_vlen_fetch_decode (
      .clk(clk), .rst_n(rst_n), .win_i(win), .imem_err_i(vec_err && !use_mem),
      .pc_o(pc), .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb),
      .valc_o(valc), .valp_o(valp), .dec_stat_o(dstat), .stat_o(stat)
   );

   vlen_fetch_decode #(.RESET_PC(32'hFFFF_FFFC)) i_vlen_fetch_decode_wrap (
      .clk(clk), .rst_n(rst_n), .win_i(48'h0000_abcd_8230), .imem_err_i(1'b0),
      .pc_o(w_pc), .icode_o(w_icode), .ifun_o(w_ifun), .ra_o(w_ra), .rb_o(w_rb),
      .valc_o(w_valc), .valp_o(w_valp), .dec_stat_o(w_dstat), .stat_o(w_stat)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // window(48) err(1) icode ifun ra rb (4 each) valc(32) len(3) dstat(3)
   localparam int NV = 20;
   localparam logic [102:0] VEC [NV] = '{
      {48'h0000_abcd_8230, 1'b0, 4'h3, 4'h0, 4'h8, 4'h2, 32'h0000_abcd, 3'd6, 3'd1},
      {48'h0000_0000_0660, 1'b0, 4'h6, 4'h0, 4'h0, 4'h6, 32'h0,         3'd2, 3'd1},
      {48'hffff_fff4_1550, 1'b0, 4'h5, 4'h0, 4'h1, 4'h5, 32'hffff_fff4, 3'd6, 3'd1},
      {48'h0000_041c_6440, 1'b0, 4'h4, 4'h0, 4'h6, 4'h4, 32'h0000_041c, 3'd6, 3'd1},
      {48'h9900_0012_3471, 1'b0, 4'h7, 4'h1, 4'hf, 4'hf, 32'h0000_1234, 3'd5, 3'd1},
      {48'h00de_adbe_ef80, 1'b0, 4'h8, 4'h0, 4'hf, 4'hf, 32'hdead_beef, 3'd5, 3'd1},
      {48'h0000_0000_5590, 1'b0, 4'h9, 4'h0, 4'hf, 4'hf, 32'h0,         3'd1, 3'd1},
      {48'h0000_0000_2fa0, 1'b0, 4'ha, 4'h0, 4'h2, 4'hf, 32'h0,         3'd2, 3'd1},
      {48'h0000_0000_3fb0, 1'b0, 4'hb, 4'h0, 4'h3, 4'hf, 32'h0,         3'd2, 3'd1},
      {48'h0000_0000_1226, 1'b0, 4'h2, 4'h6, 4'h1, 4'h2, 32'h0,         3'd2, 3'd1},
      {48'h0000_0000_0163, 1'b0, 4'h6, 4'h3, 4'h0, 4'h1, 32'h0,         3'd2, 3'd1},
      {48'h0000_0000_1227, 1'b0, 4'h2, 4'h7, 4'h1, 4'h2, 32'h0,         3'd2, 3'd4},
      {48'h0000_0000_1264, 1'b0, 4'h6, 4'h4, 4'h1, 4'h2, 32'h0,         3'd2, 3'd4},
      {48'h0000_0000_00c0, 1'b0, 4'hc, 4'h0, 4'hf, 4'hf, 32'h0,         3'd1, 3'd4},
      {48'h0000_0000_0011, 1'b0, 4'h1, 4'h1, 4'hf, 4'hf, 32'h0,         3'd1, 3'd4},
      {48'h0000_0000_0077, 1'b0, 4'h7, 4'h7, 4'hf, 4'hf, 32'h0,         3'd5, 3'd4},
      {48'h0000_0000_0005, 1'b0, 4'h0, 4'h5, 4'hf, 4'hf, 32'h0,         3'd1, 3'd4},
      {48'h0000_0000_0000, 1'b0, 4'h0, 4'h0, 4'hf, 4'hf, 32'h0,         3'd1, 3'd2},
      {48'h0000_0000_00c0, 1'b1, 4'hc, 4'h0, 4'hf, 4'hf, 32'h0,         3'd1, 3'd3},
      {48'h0000_0000_0010, 1'b1, 4'h1, 4'h0, 4'hf, 4'hf, 32'h0,         3'd1, 3'd3}
   };

   localparam int NP = 7;
   localparam logic [31:0] PC_SEQ [NP] = '{32'd0, 32'd6, 32'd8, 32'd10, 32'd15, 32'd17, 32'd18};

   initial begin
      for (int a = 0; a < 32; a++) mem[a] = 8'h00;
      {mem[0], mem[1], mem[2], mem[3], mem[4], mem[5]} = {8'h30, 8'hf2, 8'hcd, 8'hab, 8'h00, 8'h00};
      {mem[6], mem[7], mem[8], mem[9]} = {8'h60, 8'h02, 8'h20, 8'h43};
      {mem[10], mem[11], mem[12], mem[13], mem[14]} = {8'h70, 8'h01, 8'h00, 8'h00, 8'h00};
      {mem[15], mem[16], mem[17], mem[18]} = {8'ha0, 8'h0f, 8'h10, 8'h00};

      // R8: reset state
      repeat (2) @(negedge clk);
      chk("R8 reset pc", pc, 32'h0);
      chk("R8 reset stat", 32'(stat), 32'd1);

      for (int v = 0; v < NV; v++) begin
         logic [102:0] e;
         e = VEC[v];
         @(negedge clk);
         rst_n   = 1'b0;
         vec_win = e[102:55];
         vec_err = e[54];
         @(negedge clk);
         rst_n = 1'b1;
         #1;
         chk("R1 icode", 32'(icode), 32'(e[53:50]));
         chk("R1 ifun", 32'(ifun), 32'(e[49:46]));
         chk("R3 ra", 32'(ra), 32'(e[45:42]));
         chk("R3 rb", 32'(rb), 32'(e[41:38]));
         chk("R4 valc", valc, e[37:6]);
         chk("R2 valp", valp, 32'(e[5:3]));
         chk("R5 R6 R7 dec_stat", 32'(dstat), 32'(e[2:0]));
         @(negedge clk);
         #1;
         if (e[2:0] == 3'd1) begin
            chk("R8 pc advanced", pc, 32'(e[5:3]));
            chk("R8 stat normal", 32'(stat), 32'd1);
         end else begin
            chk("R9 pc held", pc, 32'h0);
            chk("R9 stat captured", 32'(stat), 32'(e[2:0]));
         end
      end

      // R2 wraparound on the high-reset instance
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R2 wrap valp", w_valp, 32'd2);
      chk("R2 wrap pc reset", w_pc, 32'hFFFF_FFFC);
      @(negedge clk);
      #1;
      chk("R2 wrap pc loaded", w_pc, 32'd2);

      // program walk from byte memory, ending in zeroed memory
      @(negedge clk);
      rst_n   = 1'b0;
      use_mem = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NP; i++) begin
         #1;
         chk("R8 walk pc", pc, PC_SEQ[i]);
         chk("R8 walk stat", 32'(stat), 32'd1);
         if (i == 0) begin
            chk("R3 walk ra none", 32'(ra), 32'hf);
            chk("R4 walk valc", valc, 32'h0000_abcd);
         end
         if (i == 4) chk("R3 walk push rb none", 32'(rb), 32'hf);
         @(negedge clk);
      end
      for (int j = 0; j < 3; j++) begin
         #1;
         chk("R7 halt pc frozen", pc, 32'd18);
         chk("R7 halt stat", 32'(stat), 32'd2);
         @(negedge clk);
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule